// File: doc/BRIEF.md
# Programmable Binary Timer with Tap Select

This block is a 24-stage binary divider. A slow counting input, `tick_in`, is sampled by the system clock. Each high-to-low transition of that input advances the chain by one. A single output, `tap_out`, carries one stage of the upper sixteen stages, chosen by a 4-bit code. A skip control removes the lowest eight stages from the count path, so the counting input drives stage 9 directly. With skip on, the same code chooses a division ratio between 2^1 and 2^16 instead of between 2^9 and 2^24.

Two force inputs load the whole chain with ones or with zeros. A hold input freezes the count. When skip and both forces are asserted together, the chain enters a split self-test arrangement. In that arrangement the three 8-stage sections each count the same input edges in parallel, so every stage can be driven to one within 255 input edges. Afterwards, one series rollover can be checked.

The full chain state is available on `count_out` for observation.

Top module: `tap_timer`

## Requirements
- R1: A synchronous `rst` clears the chain and `tap_out` to zero, regardless of the force inputs.
- R2: With no force, hold or skip, each falling edge of `tick_in` adds one to the 24-bit count, rolling from all ones to zero. A rising edge of `tick_in` leaves the count unchanged.
- R3: With `skip_low`=1 and no force, an input edge adds one to `count_out[23:8]` (that is, 256 to the count), and `count_out[7:0]` keeps its value.
- R4: One clock after a given count and `sel` value, `tap_out` equals `count_out[8+sel]`. Stage numbering starts at 1 for bit 0, so code n chooses stage 9+n with either skip setting.
- R5: `force_hi`=1 with `force_lo`=0 loads all ones into the chain on the next clock, and `tap_out` then reads 1.
- R6: `force_lo`=1 clears the chain on the next clock in every case except the split arrangement. This takes priority over `hold`, and over `force_hi` when `skip_low`=0.
- R7: With `hold`=1 and no force, input edges are ignored and the count keeps its value.
- R8: With `skip_low`, `force_hi` and `force_lo` all 1, the three 8-bit sections each add one per input edge. They count independently, with no carry between sections.
- R9: Starting from zero in the split arrangement, 255 input edges give all ones. When the forces and skip are released together, the state is kept, and one more input edge rolls the chain to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Counting input, asynchronous to clk; advances on falling edge |
| hold | input | 1 | Freeze count when 1 |
| skip_low | input | 1 | Bypass the lowest eight stages when 1 |
| sel | input | 4 | Tap code: chooses stage 9+sel |
| force_hi | input | 1 | Load all ones |
| force_lo | input | 1 | Load all zeros |
| tap_out | output | 1 | Registered selected stage |
| count_out | output | 24 | Full chain state |

## Verification
The properties assume that control inputs are steady for the cycle they describe, that each one applies to the very next clock, and that `tick_in` is held for several clocks at each level, so that the synchronizer sees every edge. The stimulus changes controls only on the falling clock edge. It keeps `tick_in` at each level for four clocks. It moves into and out of the split arrangement only while the count is at rest, and it releases both forces and skip in the same cycle, as R9 requires.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;
  typedef enum logic [1:0] {
    MD_RUN   = 2'd0,
    MD_CLEAR = 2'd1,
    MD_FILL  = 2'd2,
    MD_SPLIT = 2'd3
  } tt_mode_e;
endpackage

// File: rtl/tt_edge_sync.sv
module tt_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  output logic fall
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= tick_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[MSB-1:0], tick_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[MSB];
  end

  assign fall = prev_q & ~sync_q[MSB];
endmodule

// File: rtl/tt_mode_ctl.sv
module tt_mode_ctl
  import tap_timer_pkg::*;
(
  input  logic     fall,
  input  logic     hold,
  input  logic     skip_low,
  input  logic     force_hi,
  input  logic     force_lo,
  output tt_mode_e mode,
  output logic     step
);
  always_comb begin
    if (force_hi && force_lo && skip_low) mode = MD_SPLIT;
    else if (force_lo)                    mode = MD_CLEAR;
    else if (force_hi)                    mode = MD_FILL;
    else                                  mode = MD_RUN;
  end

  assign step = fall & ~hold;
endmodule

// File: rtl/tt_chain.sv
module tt_chain
  import tap_timer_pkg::*;
#(
  parameter int STAGES     = 24,
  parameter int SECT_W     = 8,
  parameter int BYP_STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  tt_mode_e          mode,
  input  logic              step,
  input  logic              skip_low,
  output logic [STAGES-1:0] cnt_q
);
  localparam int NSECT    = STAGES / SECT_W;
  localparam int BYP_SECT = BYP_STAGES / SECT_W;

  logic [NSECT-1:0] carry;
  logic [NSECT-1:0] run_en;

  assign carry[0] = step & ~skip_low;

  for (genvar g = 0; g < NSECT; g++) begin : g_sect
    localparam bit IS_ENTRY = (g == BYP_SECT);
    logic [SECT_W-1:0] sec_q;
    logic              inject;

    assign inject    = IS_ENTRY ? (step & skip_low) : 1'b0;
    assign run_en[g] = carry[g] | inject;

    if (g < NSECT - 1) begin : g_carry
      assign carry[g+1] = run_en[g] & (&sec_q);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        sec_q <= '0;
      end else begin
        unique case (mode)
          MD_CLEAR: sec_q <= '0;
          MD_FILL:  sec_q <= '1;
          MD_SPLIT: if (step)      sec_q <= sec_q + 1'b1;
          default:  if (run_en[g]) sec_q <= sec_q + 1'b1;
        endcase
      end
    end

    assign cnt_q[g*SECT_W +: SECT_W] = sec_q;
  end
endmodule

// File: rtl/tt_tap_sel.sv
module tt_tap_sel #(
  parameter int STAGES = 24,
  parameter int TAPS   = 16,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAGES-1:0] cnt,
  input  logic [SEL_W-1:0]  sel,
  output logic              tap_q
);
  localparam int BASE = STAGES - TAPS;

  logic [TAPS-1:0] upper;
  assign upper = cnt[STAGES-1:BASE];

  logic unused_low;
  assign unused_low = ^cnt[BASE-1:0];

  always_ff @(posedge clk) begin
    if (rst) tap_q <= 1'b0;
    else     tap_q <= upper[sel];
  end
endmodule

// File: rtl/tap_timer.sv
module tap_timer
  import tap_timer_pkg::*;
#(
  parameter int STAGES      = 24,
  parameter int SECT_W      = 8,
  parameter int BYP_STAGES  = 8,
  parameter int SEL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_in,
  input  logic              hold,
  input  logic              skip_low,
  input  logic [SEL_W-1:0]  sel,
  input  logic              force_hi,
  input  logic              force_lo,
  output logic              tap_out,
  output logic [STAGES-1:0] count_out
);
  localparam int TAPS = 1 << SEL_W;

  logic     fall;
  logic     step;
  tt_mode_e mode;

  tt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .tick_in(tick_in), .fall(fall)
  );

  tt_mode_ctl u_mode (
    .fall(fall), .hold(hold), .skip_low(skip_low),
    .force_hi(force_hi), .force_lo(force_lo),
    .mode(mode), .step(step)
  );

  tt_chain #(.STAGES(STAGES), .SECT_W(SECT_W), .BYP_STAGES(BYP_STAGES)) u_chain (
    .clk(clk), .rst(rst), .mode(mode), .step(step),
    .skip_low(skip_low), .cnt_q(count_out)
  );

  tt_tap_sel #(.STAGES(STAGES), .TAPS(TAPS), .SEL_W(SEL_W)) u_tap (
    .clk(clk), .rst(rst), .cnt(count_out), .sel(sel), .tap_q(tap_out)
  );
endmodule

// File: rtl/tap_timer_checker.sv
module tap_timer_checker #(
  parameter int STAGES     = 24,
  parameter int SECT_W     = 8,
  parameter int BYP_STAGES = 8,
  parameter int SEL_W      = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              hold,
  input logic              skip_low,
  input logic [SEL_W-1:0]  sel,
  input logic              force_hi,
  input logic              force_lo,
  input logic              tap_out,
  input logic [STAGES-1:0] count_out
);
  localparam int TAPS  = 1 << SEL_W;
  localparam int NSECT = STAGES / SECT_W;

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  logic [TAPS-1:0] upper;
  logic            sel_bit;
  assign upper   = count_out[STAGES-1:STAGES-TAPS];
  assign sel_bit = upper[sel];

  // R1: after a reset clock the chain reads zero
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (count_out == '0 && !tap_out));

  // R2: plain counting moves by zero or one
  p_step_by_one_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && !force_hi && !force_lo && !skip_low && !hold) |=>
      (count_out == $past(count_out) || count_out == STAGES'($past(count_out) + 1'b1)));

  // R3: skipped stages keep their value
  p_low_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && skip_low && !force_hi && !force_lo) |=>
      $stable(count_out[BYP_STAGES-1:0]));

  // R4: tap follows the chosen stage one clock later
  p_tap_follows_r4: assert property (@(posedge clk) disable iff (rst)
    armed |=> (tap_out == $past(sel_bit)));

  // R5: fill loads all ones
  p_fill_ones_r5: assert property (@(posedge clk) disable iff (rst)
    (force_hi && !force_lo) |=> (count_out == '1));

  // R6: clear loads zeros outside the split arrangement
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (force_lo && !(force_hi && skip_low)) |=> (count_out == '0));

  // R7: hold freezes the count
  p_hold_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && hold && !force_hi && !force_lo) |=> $stable(count_out));

  // R8: sections move in lockstep during split
  for (genvar g = 1; g < NSECT; g++) begin : g_lock
    p_split_lockstep_r8: assert property (@(posedge clk) disable iff (rst)
      (armed && force_hi && force_lo && skip_low) |=>
        (SECT_W'(count_out[g*SECT_W +: SECT_W] - $past(count_out[g*SECT_W +: SECT_W])) ==
         SECT_W'(count_out[SECT_W-1:0] - $past(count_out[SECT_W-1:0]))));
  end
endmodule

bind tap_timer tap_timer_checker #(
  .STAGES(STAGES), .SECT_W(SECT_W), .BYP_STAGES(BYP_STAGES), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst(rst), .hold(hold), .skip_low(skip_low), .sel(sel),
  .force_hi(force_hi), .force_lo(force_lo), .tap_out(tap_out),
  .count_out(count_out)
);

// File: tb/tap_timer_test.sv
`timescale 1ns/1ps
module tap_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_in = 1'b0;
  logic        hold = 1'b0;
  logic        skip_low = 1'b0;
  logic [3:0]  sel = 4'd0;
  logic        force_hi = 1'b0;
  logic        force_lo = 1'b0;
  logic        tap_out;
  logic [23:0] count_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  tap_timer uut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .hold(hold),
    .skip_low(skip_low), .sel(sel), .force_hi(force_hi),
    .force_lo(force_lo), .tap_out(tap_out), .count_out(count_out)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      tick_in = 1'b1; wait_clk(4);
      tick_in = 1'b0; wait_clk(4);
    end
  endtask

  task automatic set_force(input logic hi, input logic lo);
    force_hi = hi; force_lo = lo; wait_clk(3);
  endtask

  task automatic sweep(input string tag, input logic [23:0] exp);
    for (int s = 0; s < 16; s++) begin
      sel = 4'(s); wait_clk(2);
      check(tag, {23'd0, tap_out}, {23'd0, exp[8+s]});
    end
    sel = 4'd0;
  endtask

  task automatic t_reset;
    check("R1 count after reset", count_out, 24'h0);
    check("R1 tap after reset", {23'd0, tap_out}, 24'h0);
  endtask

  task automatic t_count;
    pulse(5);
    check("R2 five falling edges", count_out, 24'd5);
    tick_in = 1'b1; wait_clk(6);
    check("R2 rising edge ignored", count_out, 24'd5);
    tick_in = 1'b0; wait_clk(4);
    check("R2 sixth edge", count_out, 24'd6);
  endtask

  task automatic t_fill_clear;
    set_force(1'b1, 1'b0);
    check("R5 fill ones", count_out, 24'hFFFFFF);
    check("R5 tap high", {23'd0, tap_out}, 24'h1);
    set_force(1'b0, 1'b0);
    pulse(1);
    check("R2 series rollover", count_out, 24'h0);
    pulse(3);
    set_force(1'b0, 1'b1);
    check("R6 clear zeros", count_out, 24'h0);
    set_force(1'b1, 1'b0);
    set_force(1'b1, 1'b1);
    check("R6 clear beats fill without skip", count_out, 24'h0);
    set_force(1'b0, 1'b0);
  endtask

  task automatic t_bypass;
    skip_low = 1'b1; wait_clk(2);
    pulse(37);
    check("R3 upper stages count", count_out, 24'h002500);
    sweep("R4 tap sweep skip on", 24'h002500);
    set_force(1'b1, 1'b0);
    set_force(1'b0, 1'b0);
    pulse(1);
    check("R3 low stages kept", count_out, 24'h0000FF);
    skip_low = 1'b0;
    set_force(1'b0, 1'b1);
    set_force(1'b0, 1'b0);
  endtask

  task automatic t_hold;
    pulse(3);
    hold = 1'b1; wait_clk(2);
    pulse(4);
    check("R7 hold ignores edges", count_out, 24'd3);
    set_force(1'b0, 1'b1);
    check("R6 clear beats hold", count_out, 24'h0);
    set_force(1'b0, 1'b0);
    hold = 1'b0; wait_clk(2);
  endtask

  task automatic t_split;
    set_force(1'b0, 1'b1);
    skip_low = 1'b1;
    set_force(1'b1, 1'b1);
    pulse(3);
    check("R8 sections in parallel", count_out, 24'h030303);
    skip_low = 1'b0;
    set_force(1'b0, 1'b0);
    check("R9 release keeps state", count_out, 24'h030303);
    sweep("R4 tap sweep skip off", 24'h030303);
    set_force(1'b0, 1'b1);
    skip_low = 1'b1;
    set_force(1'b1, 1'b1);
    pulse(255);
    check("R9 split fill after 255", count_out, 24'hFFFFFF);
    skip_low = 1'b0;
    set_force(1'b0, 1'b0);
    pulse(1);
    check("R9 ripple to zero", count_out, 24'h0);
  endtask

  initial begin
    wait_clk(3);
    rst = 1'b0;
    wait_clk(2);
    t_reset();
    t_count();
    t_fill_clear();
    t_bypass();
    t_hold();
    t_split();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule